// File: doc/BRIEF.md
# Genlock Reference Selector and Loss-of-Sync Monitor

This block decides which of two video reference inputs feeds a genlock loop, and whether the loop runs locked to that reference or free. Each decision can come from a control byte or from an external pin. For the reference choice there is a fixed priority between a forcing pin, a register enable and a selection pin.

In genlock mode the block watches the horizontal sync of the chosen reference. It counts consecutive lines on which the pulse fails to arrive within a programmed line period plus slack. When that count goes beyond a limit held in the control byte, it declares the reference lost. The result is given as a valid status bit and as an inverted no-reference output. The holdover field is stored and passed to the outside unchanged.

Top module: `genlock_ref_monitor`

## Requirements
- R1: After reset the control byte reads 0x00, reference A and free-run are selected, `ref_ok` is 0 and `no_ref` is 1.
- R2: A write with `ctrl_wr` high loads `ctrl_wdata` into the control byte, and `ctrl_rdata` reads it back on the next cycle. The fields are: bits 2:0 missing-pulse limit, bit 3 holdover, bit 4 register reference select, bit 5 register reference enable, bit 6 register mode, bit 7 register mode enable.
- R3: `use_ref_b` equals control bit 4 when `pin_force_reg` is 1, or when control bit 5 is 1. Otherwise it equals `pin_ref_sel`. The value 0 means reference A and 1 means reference B.
- R4: `genlock_mode` equals control bit 6 when control bit 7 is 1. Otherwise it equals `pin_genlock`. The value 1 means genlock.
- R5: In genlock mode, `ref_ok` becomes 1 after four consecutive rising sync edges on the selected reference, each arriving within `period_cyc + slack_cyc` cycles of the previous event.
- R6: Each window of `period_cyc + slack_cyc` cycles that passes without a sync edge is one miss. Any edge clears the miss count. `ref_ok` drops when the count of consecutive misses exceeds control bits 2:0, and it stays 1 while the count is at or below that value.
- R7: `no_ref` is always the inverse of `ref_ok`.
- R8: In free-run mode `ref_ok` is held at 0, even when sync pulses are present.
- R9: A change of the selected reference forces `ref_ok` to 0 on the next cycle and restarts the lock count.
- R10: Sync edges on the reference that is not selected have no effect on `ref_ok`.
- R11: `holdover` follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte readback |
| pin_force_reg | input | 1 | Forces reference choice to the register bit |
| pin_ref_sel | input | 1 | External reference select (0 = A, 1 = B) |
| pin_genlock | input | 1 | External mode select (1 = genlock) |
| hsync_a | input | 1 | Horizontal sync of reference A (asynchronous) |
| hsync_b | input | 1 | Horizontal sync of reference B (asynchronous) |
| period_cyc | input | PW | Expected line period in clock cycles |
| slack_cyc | input | PW | Extra cycles allowed beyond the period |
| use_ref_b | output | 1 | Selected reference (0 = A, 1 = B) |
| genlock_mode | output | 1 | Operating mode (1 = genlock) |
| holdover | output | 1 | Holdover-on-loss control |
| ref_ok | output | 1 | Valid reference status |
| no_ref | output | 1 | Loss-of-reference flag |

## Verification
The selection logic is driven through every combination of forcing pin, register enable, register bit and pin value. This separates the three priority levels. Sync is applied as a steady train, as a train cut off after a known edge, and as a train moved to the unselected input. These patterns tell a stalled count apart from a count that tolerates exactly the limit. They also distinguish a detector that wrongly listens to both references. Leaving genlock and switching the reference while locked show the forced-loss paths.

// File: rtl/genlock_ref_monitor.sv
module genlock_ref_monitor #(
  parameter int PW     = 12,
  parameter int GOOD_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_rdata,
  input  logic          pin_force_reg,
  input  logic          pin_ref_sel,
  input  logic          pin_genlock,
  input  logic          hsync_a,
  input  logic          hsync_b,
  input  logic [PW-1:0] period_cyc,
  input  logic [PW-1:0] slack_cyc,
  output logic          use_ref_b,
  output logic          genlock_mode,
  output logic          holdover,
  output logic          ref_ok,
  output logic          no_ref
);
  localparam int TW = PW + 1;
  localparam int GW = $clog2(GOOD_N + 1);
  localparam logic [3:0] MISS_SAT = 4'd8;

  logic [7:0]    ctrl;
  logic [2:0]    sa, sb;
  logic [TW-1:0] timer;
  logic [3:0]    miss_cnt;
  logic [GW-1:0] good_cnt;
  logic          sel_q, gl_q;

  assign ctrl_rdata   = ctrl;
  assign holdover     = ctrl[3];
  assign use_ref_b    = (pin_force_reg | ctrl[5]) ? ctrl[4] : pin_ref_sel;
  assign genlock_mode = ctrl[7] ? ctrl[6] : pin_genlock;
  assign no_ref       = ~ref_ok;

  wire edge_a    = sa[1] & ~sa[2];
  wire edge_b    = sb[1] & ~sb[2];
  wire sel_edge  = use_ref_b ? edge_b : edge_a;
  wire [TW-1:0] win = {1'b0, period_cyc} + {1'b0, slack_cyc};
  wire miss      = (timer == win) & ~sel_edge;
  wire restart   = ~genlock_mode | (use_ref_b != sel_q) | ~gl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; sa <= '0; sb <= '0;
      sel_q <= 1'b0; gl_q <= 1'b0;
      timer <= '0; miss_cnt <= '0; good_cnt <= '0; ref_ok <= 1'b0;
    end else begin
      sa    <= {sa[1:0], hsync_a};
      sb    <= {sb[1:0], hsync_b};
      sel_q <= use_ref_b;
      gl_q  <= genlock_mode;
      if (ctrl_wr) ctrl <= ctrl_wdata;
      if (restart) begin
        timer <= '0; miss_cnt <= '0; good_cnt <= '0; ref_ok <= 1'b0;
      end else if (sel_edge) begin
        timer    <= '0;
        miss_cnt <= '0;
        if (good_cnt == GW'(GOOD_N - 1)) ref_ok <= 1'b1;
        if (good_cnt != GW'(GOOD_N)) good_cnt <= good_cnt + 1'b1;
      end else if (miss) begin
        timer    <= '0;
        good_cnt <= '0;
        if (miss_cnt != MISS_SAT) miss_cnt <= miss_cnt + 1'b1;
        if (miss_cnt >= {1'b0, ctrl[2:0]}) ref_ok <= 1'b0;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  // R8
  freerun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !genlock_mode |=> !ref_ok);
  // R9
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ref_b != sel_q) |=> !ref_ok);
  // R6
  loss_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && miss_cnt >= {1'b0, ctrl[2:0]}) |=> !ref_ok);
  // R5
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ok) |-> $past(sel_edge));
endmodule

// File: tb/genlock_ref_monitor_test.sv
module genlock_ref_monitor_test;
  logic clk = 0, rst_n = 0, ctrl_wr = 0;
  logic [7:0] ctrl_wdata = 0, ctrl_rdata;
  logic pin_force_reg = 0, pin_ref_sel = 0, pin_genlock = 0;
  logic hsync_a = 0, hsync_b = 0, en_a = 0, en_b = 0;
  logic [11:0] period_cyc = 12'd20, slack_cyc = 12'd4;
  logic use_ref_b, genlock_mode, holdover, ref_ok, no_ref;
  int compared = 0, mismatched = 0, gcnt = 0;

  always #10 clk = ~clk;

  genlock_ref_monitor uut (.*);

  initial forever begin
    @(negedge clk);
    gcnt = (gcnt == 19) ? 0 : gcnt + 1;
    hsync_a = en_a && gcnt < 2;
    hsync_b = en_b && gcnt < 2;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
    compared++;
    if (no_ref !== ~ref_ok) begin
      mismatched++;
      $display("FAIL R7: actual no_ref %b expected %b", no_ref, ~ref_ok);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_rdata, 8'h00);
    chk("R1 ok", {7'b0, ref_ok}, 8'h00);
    chk("R1 no_ref", {7'b0, no_ref}, 8'h01);
    chk("R1 sel", {6'b0, use_ref_b, genlock_mode}, 8'h00);
  endtask

  task automatic t_regs;
    wr(8'h5A); chk("R2 readback", ctrl_rdata, 8'h5A);
    chk("R11 holdover", {7'b0, holdover}, 8'h01);
    wr(8'h00); chk("R11 holdover clear", {7'b0, holdover}, 8'h00);
  endtask

  task automatic t_refsel;
    for (int i = 0; i < 16; i++) begin
      logic f, en, rb, p, e;
      f = i[3]; en = i[2]; rb = i[1]; p = i[0];
      wr({2'b00, en, rb, 4'h0});
      pin_force_reg = f; pin_ref_sel = p;
      @(negedge clk);
      e = (f | en) ? rb : p;
      chk("R3 priority", {7'b0, use_ref_b}, {7'b0, e});
    end
    pin_force_reg = 0; pin_ref_sel = 0;
  endtask

  task automatic t_mode;
    for (int i = 0; i < 8; i++) begin
      logic en, mb, p, e;
      en = i[2]; mb = i[1]; p = i[0];
      wr({en, mb, 6'h0});
      pin_genlock = p;
      @(negedge clk);
      e = en ? mb : p;
      chk("R4 mode", {7'b0, genlock_mode}, {7'b0, e});
    end
    pin_genlock = 0;
  endtask

  task automatic t_lock;
    en_a = 0; en_b = 0;
    wait_cyc(60);
    wr(8'hC2);
    en_a = 1;
    repeat (3) @(posedge hsync_a);
    wait_cyc(8);
    chk("R5 three edges", {7'b0, ref_ok}, 8'h00);
    @(posedge hsync_a);
    wait_cyc(8);
    chk("R5 four edges", {7'b0, ref_ok}, 8'h01);
  endtask

  task automatic t_loss;
    @(posedge hsync_a);
    wait_cyc(3);
    en_a = 0;
    wait_cyc(57);
    chk("R6 within limit", {7'b0, ref_ok}, 8'h01);
    wait_cyc(25);
    chk("R6 beyond limit", {7'b0, ref_ok}, 8'h00);
  endtask

  task automatic t_other;
    t_lock();
    @(posedge hsync_a);
    wait_cyc(3);
    en_a = 0; en_b = 1;
    wait_cyc(100);
    chk("R10 other ref ignored", {7'b0, ref_ok}, 8'h00);
    en_b = 0;
  endtask

  task automatic t_switch;
    t_lock();
    en_b = 1;
    pin_ref_sel = 1;
    wait_cyc(2);
    chk("R9 forced loss", {7'b0, ref_ok}, 8'h00);
    chk("R9 ref B", {7'b0, use_ref_b}, 8'h01);
    repeat (4) @(posedge hsync_b);
    wait_cyc(8);
    chk("R10 relock on B", {7'b0, ref_ok}, 8'h01);
    pin_force_reg = 1;
    wait_cyc(2);
    chk("R3 force to reg A", {7'b0, use_ref_b}, 8'h00);
    chk("R9 loss on force", {7'b0, ref_ok}, 8'h00);
    pin_force_reg = 0; pin_ref_sel = 0; en_b = 0;
  endtask

  task automatic t_freerun;
    t_lock();
    wr(8'h82);
    wait_cyc(100);
    chk("R8 free-run loss", {7'b0, ref_ok}, 8'h00);
    en_a = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1;
    wait_cyc(2);
    t_reset();
    t_regs();
    t_refsel();
    t_mode();
    t_lock();
    t_loss();
    t_other();
    t_switch();
    t_freerun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule